// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external byte-wide asynchronous static RAM that is selected by a pair of chip enables, one active low and one active high. The host issues single-beat requests over a valid/ready channel. Each request carries an address, a write flag and write data. The controller turns every accepted request into a complete pin-level read or write cycle. Read results come back on a response strobe with its data byte.

All memory timing minimums are parameters in nanoseconds, next to the clock period. They are turned into whole cycle counts by rounding up. The read strobe window covers the address-to-data, output-enable-to-data and read-cycle minimums. The write pulse covers the pulse-width, address-setup and data-setup minimums. A recovery phase stretches the write to the full write-cycle time. After every read, a turnaround phase waits out the memory's output float time before the controller may drive the data bus again.

Back-pressure rules: a request transfers on a clock edge where both `req_valid` and `req_ready` are high. The host must hold the address, write flag and data steady while `req_valid` is high and `req_ready` is low. `req_ready` is high only while the controller is idle and out of reset. The response channel has no back-pressure: `rsp_valid` is a single-cycle strobe that the host must take when it appears.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the outputs hold their idle values: `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0. `req_ready` stays 0 while reset is held.
- R2: An accepted read drives `mem_sel_n`=0, `mem_sel`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for exactly RD_CYC cycles, starting in the cycle after acceptance. RD_CYC is the largest of ceil(T_AA/T_CLK), ceil(T_OE/T_CLK) and ceil(T_RC/T_CLK), which is 12 with the default values. The two enables always toggle together.
- R3: The byte on `mem_dq_in` in the last cycle of the read window is returned on `rsp_rdata`. It is returned in the first cycle after the window, with `rsp_valid` high for exactly that one cycle.
- R4: An accepted write drives `mem_sel_n`=0, `mem_sel`=1, `mem_we_n`=0, `mem_oe_n`=1, `mem_dq_oe`=1 and the request's byte on `mem_dq_out` for exactly WP_CYC cycles, starting in the cycle after acceptance. WP_CYC is the largest of ceil(T_WP/T_CLK), ceil(T_AW/T_CLK) and ceil(T_DS/T_CLK), which is 9 with the default values.
- R5: After the write pulse, the enables and `mem_we_n` go inactive together. Address and data then stay driven, with `mem_dq_oe`=1, for REC_CYC cycles. REC_CYC is max(1, ceil(T_WC/T_CLK) − WP_CYC), which is 3 with the default values.
- R6: After a read window, the controller drives neither the enables nor the data bus for HZ_CYC = ceil(T_HZ/T_CLK) cycles before it returns to idle. This is 5 cycles with the default values.
- R7: `req_ready` is high only in idle, with all memory strobes inactive. A request held valid while `req_ready` is low is not taken until the controller is idle again.
- R8: `mem_dq_oe` and `mem_we_n`=0 never occur together with `mem_oe_n`=0, so the controller never drives against the memory's outputs.
- R9: `mem_addr` and `mem_dq_out` come from values latched at acceptance. They stay constant through the whole memory cycle, even if the host's request inputs change.
- R10: `rsp_valid` follows only read cycles and never follows a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (21) | Request byte address |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W (8) | Read data |
| mem_addr | output | ADDR_W (21) | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W (8) | Data bus value driven toward the memory |
| mem_dq_in | input | DATA_W (8) | Data bus value received from the memory |
| mem_dq_oe | output | 1 | Data bus driver enable |

## Verification
A sequencer stuck in the wrong phase, or a cycle counter loaded with the wrong value, shows up at the memory pins. The strobe pattern stretches or shortens by at least one cycle, and the reference model flags this on the first clock where the pins differ from its schedule. A latch that captures the wrong request, or a capture taken in the wrong cycle, appears on `mem_addr`, `mem_dq_out` or `rsp_rdata` within the same cycle. The bench checks whether `req_ready` comes back too early after a read or a write by holding a second request valid through the busy period. Any premature acceptance starts a memory cycle at the wrong time, and the model reports it at once.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD      = 3'd1,
    ST_RD_TURN = 3'd2,
    ST_WR      = 3'd3,
    ST_WR_REC  = 3'd4
  } sramc_state_e;

  // Whole cycles needed to cover a nanosecond minimum; never less than one.
  function automatic int cyc_ceil(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_wait_timer.sv
module sramc_wait_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_sequencer.sv
module sramc_sequencer
  import sramc_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int RD_CYC  = 12,
  parameter int WP_CYC  = 9,
  parameter int REC_CYC = 3,
  parameter int HZ_CYC  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output sramc_state_e     state,
  output sramc_state_e     nxt_state
);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD  = CNT_W'(HZ_CYC - 1);

  sramc_state_e state_q;

  assign req_ready = rst_n && (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt_state = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tmr_load  = 1'b1;
          nxt_state = req_write ? ST_WR : ST_RD;
          tmr_val   = req_write ? WP_LD : RD_LD;
        end
      end
      ST_RD: begin
        if (expired) begin
          nxt_state = ST_RD_TURN;
          tmr_load  = 1'b1;
          tmr_val   = HZ_LD;
        end
      end
      ST_RD_TURN: begin
        if (expired) nxt_state = ST_IDLE;
      end
      ST_WR: begin
        if (expired) begin
          nxt_state = ST_WR_REC;
          tmr_load  = 1'b1;
          tmr_val   = REC_LD;
        end
      end
      ST_WR_REC: begin
        if (expired) nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt_state;
  end

  assign state = state_q;

endmodule

// File: rtl/sramc_pin_regs.sv
module sramc_pin_regs
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  sramc_state_e      state,
  input  sramc_state_e      nxt_state,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic selected, writing, reading, driving, capture;

  assign selected = (nxt_state == ST_RD) || (nxt_state == ST_WR);
  assign writing  = (nxt_state == ST_WR);
  assign reading  = (nxt_state == ST_RD);
  assign driving  = (nxt_state == ST_WR) || (nxt_state == ST_WR_REC);
  assign capture  = (state == ST_RD) && (nxt_state == ST_RD_TURN);

  // Strobes are registered from the next state so they move with the sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      mem_sel_n <= !selected;
      mem_sel   <= selected;
      mem_we_n  <= !writing;
      mem_oe_n  <= !reading;
      mem_dq_oe <= driving;
      rsp_valid <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W        = 21,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_RC_NS       = 45,
  parameter int T_AA_NS       = 45,
  parameter int T_OE_NS       = 22,
  parameter int T_WC_NS       = 45,
  parameter int T_WP_NS       = 35,
  parameter int T_AW_NS       = 35,
  parameter int T_DS_NS       = 25,
  parameter int T_HZ_NS       = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int RD_CYC  = imax(imax(cyc_ceil(T_AA_NS, CLK_PERIOD_NS),
                                     cyc_ceil(T_OE_NS, CLK_PERIOD_NS)),
                                cyc_ceil(T_RC_NS, CLK_PERIOD_NS));
  localparam int WP_CYC  = imax(imax(cyc_ceil(T_WP_NS, CLK_PERIOD_NS),
                                     cyc_ceil(T_AW_NS, CLK_PERIOD_NS)),
                                cyc_ceil(T_DS_NS, CLK_PERIOD_NS));
  localparam int WC_CYC  = cyc_ceil(T_WC_NS, CLK_PERIOD_NS);
  localparam int REC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC) : 1;
  localparam int HZ_CYC  = cyc_ceil(T_HZ_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept, expired, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  sramc_state_e     state, nxt_state;

  sramc_sequencer #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC),
    .REC_CYC(REC_CYC), .HZ_CYC(HZ_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .expired(expired), .req_ready(req_ready), .accept(accept),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .state(state), .nxt_state(nxt_state)
  );

  sramc_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(expired)
  );

  sramc_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .state(state), .nxt_state(nxt_state),
    .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
    .mem_sel(mem_sel), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/sram_bus_ctrl_checker.sv
module sram_bus_ctrl_checker #(
  parameter int ADDR_W = 21,
  parameter int RD_CYC = 12,
  parameter int WP_CYC = 9,
  parameter int HZ_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [15:0] sel_cnt;
  logic [15:0] since_oe;

  // Cycles the memory has been selected; cycles since output enable was released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_cnt  <= '0;
      since_oe <= 16'(HZ_CYC);
    end else begin
      sel_cnt <= mem_sel_n ? 16'd0 : sel_cnt + 16'd1;
      if (!mem_oe_n)                 since_oe <= '0;
      else if (since_oe < 16'(HZ_CYC)) since_oe <= since_oe + 16'd1;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) !rst_n |=> mem_sel_n && !mem_dq_oe && mem_we_n);
  p_enable_pair_r2: assert property (@(posedge clk) disable iff (!rst_n) mem_sel_n == !mem_sel);
  p_read_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> sel_cnt == 16'(RD_CYC));
  p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n) && mem_oe_n);
  p_write_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> sel_cnt == 16'(WP_CYC));
  p_write_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_sel_n && mem_sel && mem_dq_oe);
  p_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe && $stable(mem_addr));
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> since_oe >= 16'(HZ_CYC));
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_sel_n && mem_we_n && mem_oe_n && !mem_dq_oe);
  p_no_fight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe && mem_we_n);
  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_checker #(
  .ADDR_W(ADDR_W), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_bus_ctrl_bench.sv
module sram_bus_ctrl_bench;

  // Cycle counts worked out from the requirements at a 4 ns clock.
  localparam int RD  = 12; // max(ceil(45/4), ceil(22/4), ceil(45/4))
  localparam int WP  = 9;  // max(ceil(35/4), ceil(35/4), ceil(25/4))
  localparam int REC = 3;  // ceil(45/4) - 9
  localparam int HZ  = 5;  // ceil(18/4)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [20:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #2 clk = ~clk;

  sram_bus_ctrl u_sram_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  // Behavioural memory: drives the bus only in a proper read.
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  assign mem_dq_in = (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
                     ? mem[mem_addr[7:0]] : 8'h00;

  // Expected per-cycle state: {sel_n, sel, we_n, oe_n, dq_oe, ready, rsp_valid}
  typedef struct {
    logic [6:0]  ctl;
    logic [20:0] a;
    logic [7:0]  d;
    bit          ca;
    bit          cd;
    bit          cr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  logic prev_we = 1'b1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic exp_t mk(input logic [6:0] ctl, input logic [20:0] a,
                              input logic [7:0] d, input bit ca, input bit cd,
                              input bit cr, input string tag);
    exp_t e;
    e.ctl = ctl; e.a = a; e.d = d; e.ca = ca; e.cd = cd; e.cr = cr; e.tag = tag;
    return e;
  endfunction

  always @(negedge clk) begin
    exp_t e;
    logic [6:0] ctl;
    cyc++;
    ctl = {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid};
    if (!rst_n) begin
      chk(ctl == 7'b1011000, "R1", "pins in reset", 32'(ctl), 32'(7'b1011000));
    end else begin
      if (q.size() > 0) e = q.pop_front();
      else e = mk(7'b1011010, '0, '0, 1'b0, 1'b0, 1'b0, "R7");
      chk(ctl == e.ctl, e.tag, "strobes", 32'(ctl), 32'(e.ctl));
      if (e.ca) chk(mem_addr == e.a, "R9", "address", 32'(mem_addr), 32'(e.a));
      if (e.cd) chk(mem_dq_out == e.d, "R9", "write data", 32'(mem_dq_out), 32'(e.d));
      if (e.cr) chk(rsp_rdata == e.d, "R3", "read data", 32'(rsp_rdata), 32'(e.d));
      if (req_valid && req_ready) begin
        if (req_write) begin
          for (int i = 0; i < WP; i++)
            q.push_back(mk(7'b0101100, req_addr, req_wdata, 1'b1, 1'b1, 1'b0, "R4"));
          for (int i = 0; i < REC; i++)
            q.push_back(mk(7'b1011100, req_addr, req_wdata, 1'b1, 1'b1, 1'b0, "R5"));
        end else begin
          for (int i = 0; i < RD; i++)
            q.push_back(mk(7'b0110000, req_addr, '0, 1'b1, 1'b0, 1'b0, "R2"));
          q.push_back(mk(7'b1011001, '0, shadow[req_addr[7:0]], 1'b0, 1'b0, 1'b1, "R10"));
          for (int i = 1; i < HZ; i++)
            q.push_back(mk(7'b1011000, '0, '0, 1'b0, 1'b0, 1'b0, "R6"));
        end
      end
      if (!prev_we && mem_we_n && mem_dq_oe) mem[mem_addr[7:0]] = mem_dq_out;
    end
    prev_we = mem_we_n;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_req(input bit w, input logic [20:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    if (w) shadow[a[7:0]] = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~w;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    do_req(1'b0, 21'h000040, 8'h00);          // R2 read of untouched cell
    do_req(1'b1, 21'h000011, 8'hC3);          // R6 write right after a read
    do_req(1'b1, 21'h1F0022, 8'h00);          // R4 all-zero data
    do_req(1'b1, 21'h0A5533, 8'hFF);          // R4 all-one data
    do_req(1'b1, 21'h1FFFFF, 8'hA5);          // R9 top address
    do_req(1'b0, 21'h000011, 8'h00);          // R3 read back
    do_req(1'b0, 21'h1F0022, 8'h00);          // back-to-back reads
    do_req(1'b0, 21'h0A5533, 8'h00);
    do_req(1'b0, 21'h1FFFFF, 8'h00);
    do_req(1'b1, 21'h000011, 8'h3C);          // R10 overwrite, no response
    do_req(1'b0, 21'h000011, 8'h00);
    repeat (40) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule